// File: doc/BRIEF.md
# Multi-mode 24-bit event counter core

This core counts single-cycle step strobes up or down in a 24-bit register. The arithmetic can be plain binary, six-digit decimal (one BCD digit per nibble), or time of day. In time-of-day mode the low byte holds seconds, the middle byte minutes and the high byte hours, each as two BCD digits. Each step is taken in one clock cycle. A wrap past the top or bottom of the active range counts as a carry or a borrow. A wrap either returns the count to the far end of the range, reloads it from the preset register (divide-by-N), or stops further counting until the next load or clear (non-recycle).

The core keeps a preset register and compares every new count value against it. It keeps toggle flags for carry, borrow and compare, and a sign flag that records the direction of the last wrap. Two output pins are driven from a selectable pair of these status signals. All commands are synchronous inputs that last one cycle: write the mode word, write the preset, clear the count, load the count from the preset, and clear the compare toggle. Bus decoding is left to the surrounding logic.

Top module: `evcnt24_core`

## Requirements
- R1: After reset: count 0, preset FFFFFF, all toggle flags 0, sign 1, all pulses 0, mode word 0, and both pins high (select 00).
- R2: With mode bits 0 and 3 clear (binary), a step adds or subtracts 1 modulo 2^24. Overflow is FFFFFF going up to 000000, and underflow is 000000 going down to FFFFFF.
- R3: With mode bit 0 set and bit 3 clear (BCD), each nibble is a decimal digit and the count runs from 000000 to 999999. Overflow is 999999 to 000000, and underflow is the reverse.
- R4: With mode bit 3 set (time of day, whatever bit 0 holds), bits 7:0 are seconds 00-59, bits 15:8 are minutes 00-59 and bits 23:16 are hours 00-23, all in BCD. Overflow is 235959 to 000000, and underflow is the reverse.
- R5: On overflow, carry_pulse is 1 for exactly the one cycle in which the wrapped count appears, carry_tgl inverts and sign becomes 1. On underflow, borrow_pulse behaves the same way, borrow_tgl inverts and sign becomes 0.
- R6: With mode bit 2 set (divide-by-N), an overflow or underflow loads the preset value into the count instead of the wrapped value.
- R7: With mode bit 1 set (non-recycle), a wrap produces no carry or borrow pulse, but the toggle and sign flags still update. Steps then have no effect until a clear or load.
- R8: cmd_clear sets the count to 0, clears carry_tgl and borrow_tgl, and sets sign. It takes priority over cmd_load and over a step in the same cycle.
- R9: cmd_load copies the preset held before that edge into the count, and takes priority over a step. A preset write changes the preset but not the count.
- R10: When the count is updated (clear, load or step) and the new value equals the preset, cmp_pulse is 1 for one cycle and cmp_tgl inverts. cmd_cmp_clr forces cmp_tgl to 0.
- R11: Mode bits 5:4 select the pins (pin_a, pin_b): 00 gives inverted carry and borrow pulses, 01 gives carry_tgl and borrow_tgl, 10 gives the carry and borrow pulses, and 11 gives cmp_pulse and cmp_tgl.
- R12: A cycle with no clear, no load and step_en low leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| cfg_wr | input | 1 | Write cfg_word into the mode register |
| cfg_word | input | 6 | Mode word: bit0 BCD, bit1 non-recycle, bit2 divide-by-N, bit3 time of day, bits5:4 pin select |
| preset_wr | input | 1 | Write preset_data into the preset register |
| preset_data | input | 24 | New preset value |
| cmd_clear | input | 1 | Clear the count and the carry and borrow toggles, and set sign |
| cmd_load | input | 1 | Load the count from the preset |
| cmd_cmp_clr | input | 1 | Clear the compare toggle |
| step_en | input | 1 | Take one count step this cycle |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| count | output | 24 | Current count |
| carry_tgl | output | 1 | Carry toggle flag |
| borrow_tgl | output | 1 | Borrow toggle flag |
| cmp_tgl | output | 1 | Compare toggle flag |
| sign | output | 1 | Sign flag |
| carry_pulse | output | 1 | One-cycle overflow pulse |
| borrow_pulse | output | 1 | One-cycle underflow pulse |
| cmp_pulse | output | 1 | One-cycle compare-match pulse |
| pin_a | output | 1 | First selectable status pin |
| pin_b | output | 1 | Second selectable status pin |

## Verification
Every result is registered, so the count, the flags and the three pulses all take their new values on the first rising edge after a command or step is presented. The pins follow combinationally from those registers in the same cycle. The bench applies stimulus just after a falling edge and advances its reference model by one step. It then compares every output at the next falling edge, half a period after the edge that produced the result. After rst_n rises, the synchronizer holds the core in reset for two more edges, so the bench waits several cycles before its first command.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Mode word layout; bit positions are decoded by the core.
  typedef struct packed {
    logic [1:0] pin_sel;   // [5:4]
    logic       clock24;   // [3]
    logic       divn;      // [2]
    logic       nonrec;    // [1]
    logic       bcd;       // [0]
  } evc_mode_t;

  localparam int MODE_W = $bits(evc_mode_t);

  localparam logic [1:0] PIN_CB_LOW  = 2'b00;
  localparam logic [1:0] PIN_TOGGLES = 2'b01;
  localparam logic [1:0] PIN_CB_HIGH = 2'b10;
  localparam logic [1:0] PIN_COMPARE = 2'b11;

endpackage

// File: rtl/evc_byte_stage.sv
module evc_byte_stage #(
  parameter int BYTE_IDX = 0
) (
  input  logic [7:0] val,
  input  logic       step,
  input  logic       up,
  input  logic       bcd,
  input  logic       clock24,
  output logic [7:0] nxt,
  output logic       wrap
);

  localparam logic [7:0] CLK_LIM = (BYTE_IDX >= 2) ? 8'h23 : 8'h59;

  logic       is_bin;
  logic [7:0] lim;

  always_comb begin
    is_bin = !bcd && !clock24;
    if (clock24)   lim = CLK_LIM;
    else if (bcd)  lim = 8'h99;
    else           lim = 8'hFF;
  end

  always_comb begin
    nxt  = val;
    wrap = 1'b0;
    if (step) begin
      if (up) begin
        if (val == lim) begin
          nxt  = 8'h00;
          wrap = 1'b1;
        end else if (!is_bin && (val[3:0] == 4'd9)) begin
          nxt = {val[7:4] + 4'd1, 4'd0};
        end else begin
          nxt = val + 8'd1;
        end
      end else begin
        if (val == 8'h00) begin
          nxt  = lim;
          wrap = 1'b1;
        end else if (!is_bin && (val[3:0] == 4'd0)) begin
          nxt = {val[7:4] - 4'd1, 4'd9};
        end else begin
          nxt = val - 8'd1;
        end
      end
    end
  end

endmodule

// File: rtl/evc_step_unit.sv
module evc_step_unit
  import evc_pkg::*;
#(
  parameter int N_BYTES = 3,
  localparam int CNT_W = 8 * N_BYTES
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             step,
  input  logic             up,
  input  evc_mode_t        mode,
  output logic [CNT_W-1:0] nxt,
  output logic             wrap
);

  logic [N_BYTES:0] chain;

  assign chain[0] = step;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    evc_byte_stage #(.BYTE_IDX(i)) u_stage (
      .val     (cnt[8*i +: 8]),
      .step    (chain[i]),
      .up      (up),
      .bcd     (mode.bcd),
      .clock24 (mode.clock24),
      .nxt     (nxt[8*i +: 8]),
      .wrap    (chain[i+1])
    );
  end

  assign wrap = chain[N_BYTES];

endmodule

// File: rtl/evc_pin_mux.sv
module evc_pin_mux
  import evc_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       cy,
  input  logic       bw,
  input  logic       cy_t,
  input  logic       bw_t,
  input  logic       cmp,
  input  logic       cmp_t,
  output logic       pin_a,
  output logic       pin_b
);

  always_comb begin
    case (sel)
      PIN_CB_LOW:  begin pin_a = ~cy;  pin_b = ~bw;   end
      PIN_TOGGLES: begin pin_a = cy_t; pin_b = bw_t;  end
      PIN_CB_HIGH: begin pin_a = cy;   pin_b = bw;    end
      default:     begin pin_a = cmp;  pin_b = cmp_t; end
    endcase
  end

endmodule

// File: rtl/evcnt24_core.sv
module evcnt24_core
  import evc_pkg::*;
#(
  parameter int N_BYTES = 3,
  localparam int CNT_W = 8 * N_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_word,
  input  logic              preset_wr,
  input  logic [CNT_W-1:0]  preset_data,
  input  logic              cmd_clear,
  input  logic              cmd_load,
  input  logic              cmd_cmp_clr,
  input  logic              step_en,
  input  logic              step_up,
  output logic [CNT_W-1:0]  count,
  output logic              carry_tgl,
  output logic              borrow_tgl,
  output logic              cmp_tgl,
  output logic              sign,
  output logic              carry_pulse,
  output logic              borrow_pulse,
  output logic              cmp_pulse,
  output logic              pin_a,
  output logic              pin_b
);

  // Reset: asserted asynchronously, released on the second edge.
  logic [1:0] rs_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  // State
  evc_mode_t        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, pre_q, pre_d;
  logic             ct_q, ct_d, bt_q, bt_d, cmpt_q, cmpt_d;
  logic             sign_q, sign_d, run_q, run_d;
  logic             cy_q, cy_d, bw_q, bw_d, cmp_q, cmp_d;
  logic             upd, step_ok;
  logic [CNT_W-1:0] step_nxt;
  logic             step_wrap;

  assign step_ok = step_en && (run_q || !mode_q.nonrec);

  evc_step_unit #(.N_BYTES(N_BYTES)) u_step (
    .cnt  (cnt_q),
    .step (step_ok),
    .up   (step_up),
    .mode (mode_q),
    .nxt  (step_nxt),
    .wrap (step_wrap)
  );

  // Next state
  always_comb begin
    mode_d = cfg_wr    ? evc_mode_t'(cfg_word) : mode_q;
    pre_d  = preset_wr ? preset_data           : pre_q;
    cnt_d  = cnt_q;
    ct_d   = ct_q;
    bt_d   = bt_q;
    sign_d = sign_q;
    run_d  = run_q;
    cy_d   = 1'b0;
    bw_d   = 1'b0;
    upd    = 1'b0;
    if (cmd_clear) begin
      cnt_d  = '0;
      ct_d   = 1'b0;
      bt_d   = 1'b0;
      sign_d = 1'b1;
      run_d  = 1'b1;
      upd    = 1'b1;
    end else if (cmd_load) begin
      cnt_d = pre_q;
      run_d = 1'b1;
      upd   = 1'b1;
    end else if (step_ok) begin
      upd = 1'b1;
      if (!step_wrap) begin
        cnt_d = step_nxt;
      end else begin
        cnt_d = mode_q.divn ? pre_q : step_nxt;
        if (mode_q.nonrec) run_d = 1'b0;
        if (step_up) begin
          cy_d   = !mode_q.nonrec;
          ct_d   = !ct_q;
          sign_d = 1'b1;
        end else begin
          bw_d   = !mode_q.nonrec;
          bt_d   = !bt_q;
          sign_d = 1'b0;
        end
      end
    end
    cmp_d  = upd && (cnt_d == pre_q);
    cmpt_d = cmd_cmp_clr ? 1'b0 : (cmpt_q ^ cmp_d);
  end

  // Registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      mode_q <= '0;
      pre_q  <= '1;
      cnt_q  <= '0;
      ct_q   <= 1'b0;
      bt_q   <= 1'b0;
      cmpt_q <= 1'b0;
      sign_q <= 1'b1;
      run_q  <= 1'b1;
      cy_q   <= 1'b0;
      bw_q   <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      if (cfg_wr)    mode_q <= mode_d;
      if (preset_wr) pre_q  <= pre_d;
      if (upd)       cnt_q  <= cnt_d;
      ct_q   <= ct_d;
      bt_q   <= bt_d;
      cmpt_q <= cmpt_d;
      sign_q <= sign_d;
      run_q  <= run_d;
      cy_q   <= cy_d;
      bw_q   <= bw_d;
      cmp_q  <= cmp_d;
    end
  end

  evc_pin_mux u_pins (
    .sel   (mode_q.pin_sel),
    .cy    (cy_q),
    .bw    (bw_q),
    .cy_t  (ct_q),
    .bw_t  (bt_q),
    .cmp   (cmp_q),
    .cmp_t (cmpt_q),
    .pin_a (pin_a),
    .pin_b (pin_b)
  );

  assign count        = cnt_q;
  assign carry_tgl    = ct_q;
  assign borrow_tgl   = bt_q;
  assign cmp_tgl      = cmpt_q;
  assign sign         = sign_q;
  assign carry_pulse  = cy_q;
  assign borrow_pulse = bw_q;
  assign cmp_pulse    = cmp_q;

endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             cmd_clear,
  input logic             cmd_load,
  input logic             step_en,
  input logic             cfg_wr,
  input logic             nonrec,
  input logic [CNT_W-1:0] pre_q,
  input logic [CNT_W-1:0] count,
  input logic             sign,
  input logic             carry_pulse,
  input logic             borrow_pulse,
  input logic             carry_tgl,
  input logic             borrow_tgl
);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    cmd_clear |=> (count == '0) && sign && !carry_tgl && !borrow_tgl); // R8

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cmd_clear && cmd_load) |=> (count == $past(pre_q))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cmd_clear && !cmd_load && !step_en) |=> $stable(count)); // R12

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_ok)
    !(carry_pulse && borrow_pulse)); // R5

  AST_CARRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_ok)
    carry_pulse |-> (sign && (carry_tgl != $past(carry_tgl)))); // R5

  AST_BORROW_FLAGS: assert property (@(posedge clk) disable iff (!rst_ok)
    borrow_pulse |-> (!sign && (borrow_tgl != $past(borrow_tgl)))); // R5

  AST_NONREC_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    (nonrec && !cfg_wr) |=> (!carry_pulse && !borrow_pulse)); // R7

endmodule

bind evcnt24_core evc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_ok       (core_rst_n),
  .cmd_clear    (cmd_clear),
  .cmd_load     (cmd_load),
  .step_en      (step_en),
  .cfg_wr       (cfg_wr),
  .nonrec       (mode_q.nonrec),
  .pre_q        (pre_q),
  .count        (count),
  .sign         (sign),
  .carry_pulse  (carry_pulse),
  .borrow_pulse (borrow_pulse),
  .carry_tgl    (carry_tgl),
  .borrow_tgl   (borrow_tgl)
);

// File: tb/sim_evcnt24_core.sv
module sim_evcnt24_core;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int N_RANDOM   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_word = '0;
  logic        preset_wr = 1'b0;
  logic [23:0] preset_data = '0;
  logic        cmd_clear = 1'b0, cmd_load = 1'b0, cmd_cmp_clr = 1'b0;
  logic        step_en = 1'b0, step_up = 1'b0;
  logic [23:0] count;
  logic        carry_tgl, borrow_tgl, cmp_tgl, sign;
  logic        carry_pulse, borrow_pulse, cmp_pulse, pin_a, pin_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evcnt24_core u0 (.*);

  // Reference model state (value expected after the last edge)
  logic [23:0] m_cnt, m_pre;
  logic [5:0]  m_mode;
  logic        m_ct, m_bt, m_cmpt, m_sign, m_run, m_cy, m_bw, m_cmp;

  function automatic int unsigned modulus(logic [5:0] md);
    if (md[3])      return 86400;
    else if (md[0]) return 1000000;
    else            return 32'd1 << 24;
  endfunction

  function automatic int unsigned bcd2(logic [7:0] b);
    return b[7:4] * 10 + b[3:0];
  endfunction

  function automatic logic [7:0] to_bcd2(int unsigned n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int unsigned decode(logic [5:0] md, logic [23:0] v);
    if (md[3]) return bcd2(v[23:16]) * 3600 + bcd2(v[15:8]) * 60 + bcd2(v[7:0]);
    if (md[0]) return bcd2(v[23:16]) * 10000 + bcd2(v[15:8]) * 100 + bcd2(v[7:0]);
    return int'(v);
  endfunction

  function automatic logic [23:0] encode(logic [5:0] md, int unsigned n);
    if (md[3]) return {to_bcd2(n / 3600), to_bcd2((n / 60) % 60), to_bcd2(n % 60)};
    if (md[0]) return {to_bcd2(n / 10000), to_bcd2((n / 100) % 100), to_bcd2(n % 100)};
    return n[23:0];
  endfunction

  function automatic logic [1:0] exp_pins();
    case (m_mode[5:4])
      2'b00:   return {~m_cy, ~m_bw};
      2'b01:   return {m_ct, m_bt};
      2'b10:   return {m_cy, m_bw};
      default: return {m_cmp, m_cmpt};
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_pre = '1; m_mode = '0; m_ct = 0; m_bt = 0; m_cmpt = 0;
    m_sign = 1; m_run = 1; m_cy = 0; m_bw = 0; m_cmp = 0;
  endtask

  // Advance the model by one edge using the stimulus currently applied.
  task automatic model_step();
    int unsigned md, o;
    logic upd;
    logic [23:0] old_pre;
    old_pre = m_pre;
    md = modulus(m_mode);
    upd = 0; m_cy = 0; m_bw = 0;
    if (cmd_clear) begin
      m_cnt = '0; m_ct = 0; m_bt = 0; m_sign = 1; m_run = 1; upd = 1;
    end else if (cmd_load) begin
      m_cnt = old_pre; m_run = 1; upd = 1;
    end else if (step_en && (m_run || !m_mode[1])) begin
      upd = 1;
      o = decode(m_mode, m_cnt);
      if (step_up) begin
        if (o == md - 1) begin
          m_cnt = m_mode[2] ? old_pre : encode(m_mode, 0);
          m_cy = !m_mode[1]; m_ct = !m_ct; m_sign = 1;
          if (m_mode[1]) m_run = 0;
        end else m_cnt = encode(m_mode, o + 1);
      end else begin
        if (o == 0) begin
          m_cnt = m_mode[2] ? old_pre : encode(m_mode, md - 1);
          m_bw = !m_mode[1]; m_bt = !m_bt; m_sign = 0;
          if (m_mode[1]) m_run = 0;
        end else m_cnt = encode(m_mode, o - 1);
      end
    end
    m_cmp = upd && (m_cnt == old_pre);
    m_cmpt = cmd_cmp_clr ? 1'b0 : (m_cmpt ^ m_cmp);
    if (cfg_wr)    m_mode = cfg_word;
    if (preset_wr) m_pre = preset_data;
  endtask

  task automatic chk(string tag, string what, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag,  "count",        count, m_cnt);
    chk("R5", "carry_pulse",  24'(carry_pulse), 24'(m_cy));
    chk("R5", "borrow_pulse", 24'(borrow_pulse), 24'(m_bw));
    chk("R5", "carry_tgl",    24'(carry_tgl), 24'(m_ct));
    chk("R5", "borrow_tgl",   24'(borrow_tgl), 24'(m_bt));
    chk("R5", "sign",         24'(sign), 24'(m_sign));
    chk("R10", "cmp_pulse",   24'(cmp_pulse), 24'(m_cmp));
    chk("R10", "cmp_tgl",     24'(cmp_tgl), 24'(m_cmpt));
    chk("R11", "pins",        24'({pin_a, pin_b}), 24'(exp_pins()));
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; preset_wr = 0; cmd_clear = 0; cmd_load = 0;
    cmd_cmp_clr = 0; step_en = 0; step_up = 0;
  endtask

  // Called just after a falling edge with the stimulus already set.
  task automatic run_cycle(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    idle_inputs();
  endtask

  task automatic set_mode(logic [5:0] md, logic [23:0] pre, string tag);
    cfg_wr = 1; cfg_word = md; cmd_clear = 1; preset_wr = 1; preset_data = pre;
    run_cycle(tag);
  endtask

  task automatic step(logic up, string tag);
    step_en = 1; step_up = up;
    run_cycle(tag);
  endtask

  task automatic load_cnt(logic [23:0] v, string tag);
    preset_wr = 1; preset_data = v;
    run_cycle(tag);
    cmd_load = 1;
    run_cycle(tag);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C47));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    compare_all("R1");
    chk("R1", "count_zero", count, 24'h000000);

    // R12: idle and preset write leave count alone
    run_cycle("R12");
    preset_wr = 1; preset_data = 24'h123456;
    run_cycle("R12");
    step_en = 0; step_up = 1;
    run_cycle("R12");

    // R2 binary wraps, R9 load
    load_cnt(24'hFFFFFE, "R9");
    step(1, "R2"); step(1, "R2"); step(0, "R2"); step(0, "R2");

    // R3 BCD
    set_mode(6'b000001, 24'h999998, "R3");
    cmd_load = 1; run_cycle("R9");
    step(1, "R3"); step(1, "R3"); step(0, "R3");
    load_cnt(24'h000019, "R3"); step(1, "R3"); step(0, "R3"); step(0, "R3");

    // R4 time of day (bit0 also set to show the override)
    set_mode(6'b001001, 24'h235958, "R4");
    cmd_load = 1; run_cycle("R4");
    step(1, "R4"); step(1, "R4"); step(0, "R4");
    load_cnt(24'h005959, "R4"); step(1, "R4"); step(0, "R4");
    load_cnt(24'h095959, "R4"); step(1, "R4");

    // R6 divide-by-N
    set_mode(6'b000100, 24'h000005, "R6");
    step(0, "R6"); step(0, "R6");
    load_cnt(24'hFFFFFF, "R6"); step(1, "R6");

    // R7 non-recycle
    set_mode(6'b010010, 24'h000100, "R7");
    step(0, "R7"); step(0, "R7"); step(1, "R7");
    cmd_load = 1; run_cycle("R7");
    step(0, "R7");

    // R8 clear priority over load and step
    cmd_clear = 1; cmd_load = 1; step_en = 1; step_up = 1;
    run_cycle("R8");

    // R10 compare and compare clear, pin select 11
    set_mode(6'b110000, 24'h000003, "R10");
    step(1, "R10"); step(1, "R10"); step(1, "R10"); step(1, "R10");
    cmd_cmp_clr = 1; run_cycle("R10");

    // R11 each pin selection around a wrap
    for (int s = 0; s < 4; s++) begin
      set_mode({2'(s), 4'b0000}, 24'h000000, "R11");
      step(0, "R11"); step(1, "R11"); step(1, "R11");
    end

    // Constrained random mix
    for (int i = 0; i < N_RANDOM; i++) begin
      int unsigned r, md_n;
      logic [5:0] nm;
      r = $urandom % 1000;
      if (r < 5) begin
        nm = 6'($urandom);
        md_n = modulus(nm);
        cfg_wr = 1; cfg_word = nm; cmd_clear = 1; preset_wr = 1;
        preset_data = encode(nm, ($urandom % 2) ? ($urandom % 40) : (md_n - 1 - $urandom % 40));
      end else begin
        md_n = modulus(m_mode);
        if (r < 15) begin
          preset_wr = 1;
          preset_data = encode(m_mode, ($urandom % 2) ? ($urandom % 40) : (md_n - 1 - $urandom % 40));
        end
        cmd_load    = ($urandom % 60) == 0;
        cmd_clear   = ($urandom % 120) == 0;
        cmd_cmp_clr = ($urandom % 50) == 0;
        step_en     = ($urandom % 10) < 7;
        step_up     = ($urandom % 2) == 1;
      end
      run_cycle("R2");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule